// File: doc/BRIEF.md
# Interrupt and Halt Controller

This block governs when a small 8-bit processor core leaves its normal instruction stream for an interrupt handler, when it comes back, and when it sleeps. It owns the interrupt-disable flag (a set flag means interrupts are blocked) and an in-handler marker. It also owns a free-running divider that produces the per-frame tick. Two request sources feed it: that frame tick and an external IO request line. The core supplies one-cycle control strobes from its decoder: disable, enable, return-from-interrupt, halt, and an instruction-boundary strobe that carries the address of the next instruction.

When an interrupt is accepted, the controller stalls the core. It streams the 16-bit return address out as two bytes on a valid/ready push port for the core's stack logic. It then pulses a vector-load strobe with the handler slot address. The frame slot is at 0xFF00 and the IO slot is at 0xFF02, and each slot holds a handler address stored low byte first. The push port follows the usual back-pressure rules. A byte is transferred on a cycle where both `push_valid` and `push_ready` are high. Once `push_valid` rises, it stays high and `push_data`/`push_last` stay unchanged until that transfer happens. `push_valid` never waits on `push_ready`.

Top module: `irq_halt_ctrl`

## Requirements
- R1: After reset, `irq_disabled` is 1, `in_handler` is 0, and `stall`, `push_valid` and `vec_load` are 0.
- R2: `frame_tick` is high for exactly one cycle in every FRAME_DIV cycles (default 133333), counting from reset release.
- R3: A `sif` strobe sets the disable flag. A `cif` strobe clears it only when no handler is active. Inside a handler, `cif` leaves the flag set.
- R4: An interrupt is accepted only on a cycle where `boundary` is high and the disable flag, after that cycle's strobes are applied, is clear. Acceptance sets the disable flag and the in-handler marker, and raises `stall` from the next cycle.
- R5: After acceptance, the return address (`next_pc` sampled at acceptance) is pushed high byte first, then low byte, and `push_last` marks the low byte. While `push_ready` is low, `push_valid`, `push_data` and `push_last` hold.
- R6: The cycle after the low byte is accepted, `vec_load` is high for exactly one cycle and `vec_addr` is 0xFF00 for a frame interrupt or 0xFF02 for an IO interrupt. `stall` drops on the following cycle.
- R7: When frame and IO requests are both pending at an accepting boundary, the frame interrupt is taken. The IO request stays pending and is taken at a later boundary.
- R8: An `iret` strobe clears both the disable flag and the in-handler marker.
- R9: `halt` with the disable flag clear raises `stall` until a frame request is pending. That frame interrupt is then accepted without a boundary strobe.
- R10: `halt` with the disable flag set raises `stall` permanently until reset. No push starts, and all strobes and requests are ignored.
- R11: An IO request seen while interrupts are disabled is remembered and taken once the flag is clear at a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_irq | input | 1 | External IO interrupt request, latched when high |
| boundary | input | 1 | Instruction-boundary strobe |
| sif | input | 1 | Disable-interrupts strobe |
| cif | input | 1 | Enable-interrupts strobe |
| iret | input | 1 | Return-from-interrupt strobe |
| halt | input | 1 | Halt strobe |
| next_pc | input | 16 | Address of the next instruction, valid with `boundary` |
| push_valid | output | 1 | Return-address byte available |
| push_ready | input | 1 | Stack logic accepts the byte |
| push_data | output | 8 | Return-address byte |
| push_last | output | 1 | Marks the final (low) byte |
| vec_load | output | 1 | One-cycle strobe: load PC from the vector slot |
| vec_addr | output | 16 | Vector slot address |
| stall | output | 1 | Freeze the core |
| irq_disabled | output | 1 | Interrupt-disable flag |
| in_handler | output | 1 | A handler is active |
| frame_tick | output | 1 | Per-frame pulse |

## Verification
The bench holds `push_ready` low across several cycles. A design that advanced or changed the byte without a handshake would push a corrupted return address. It raises both requests with interrupts disabled, then opens them at a single boundary. A design with the wrong priority would vector to 0xFF02 first, and one that dropped the losing request would never vector to 0xFF02 at all. It strobes `cif` inside a handler, which a careless flag would obey and so allow nesting. It issues `halt` both with interrupts enabled and with them disabled. The enabled case must wait out the remaining frame period and then vector to 0xFF00. The disabled case must stay stalled no matter what requests or strobes arrive.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_PUSH,
    ST_VECTOR,
    ST_HALT,
    ST_LOCK
  } irqc_state_t;

  typedef enum logic {
    SRC_FRAME = 1'b0,
    SRC_IO    = 1'b1
  } irqc_src_t;
endpackage

// File: rtl/irqc_frame_div.sv
module irqc_frame_div #(
  parameter int unsigned FRAME_DIV = 133333
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CNT_W = (FRAME_DIV > 1) ? $clog2(FRAME_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);

  generate
    if (FRAME_DIV > 1) begin : g_single
      p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending
  import irqc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame_set,
  input  logic      io_set,
  input  logic      take,
  output irqc_src_t sel_src,
  output logic      any_pend,
  output logic      frame_pend,
  output logic      io_pend
);
  logic clr_frame, clr_io;

  // frame outranks IO
  assign sel_src   = frame_pend ? SRC_FRAME : SRC_IO;
  assign any_pend  = frame_pend | io_pend;
  assign clr_frame = take & (sel_src == SRC_FRAME);
  assign clr_io    = take & (sel_src == SRC_IO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_pend <= 1'b0;
      io_pend    <= 1'b0;
    end else begin
      frame_pend <= frame_set | (frame_pend & ~clr_frame);
      io_pend    <= io_set    | (io_pend    & ~clr_io);
    end
  end

  p_io_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_pend && !clr_io) |=> io_pend);
  p_frame_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && frame_pend) |-> !clr_io);
endmodule

// File: rtl/irqc_pusher.sv
module irqc_pusher #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] ret_pc,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [DATA_W-1:0] push_data,
  output logic              push_last,
  output logic              done
);
  localparam int unsigned BYTES = ADDR_W / DATA_W;
  localparam int unsigned IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTES - 1);

  logic              busy_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] shf_q;
  logic              xfer;

  assign push_valid = busy_q;
  assign push_data  = shf_q[ADDR_W-1 -: DATA_W];
  assign push_last  = busy_q & (idx_q == LAST_IDX);
  assign xfer       = busy_q & push_ready;
  assign done       = xfer & (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      shf_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      shf_q  <= ret_pc;
    end else if (xfer) begin
      shf_q <= {shf_q[ADDR_W-DATA_W-1:0], {DATA_W{1'b0}}};
      if (idx_q == LAST_IDX) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> (push_valid && $stable(push_data) && $stable(push_last)));
  p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start);
endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned FRAME_DIV = 133333,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter logic [15:0] FRAME_VEC = 16'hFF00,
  parameter logic [15:0] IO_VEC    = 16'hFF02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_irq,
  input  logic              boundary,
  input  logic              sif,
  input  logic              cif,
  input  logic              iret,
  input  logic              halt,
  input  logic [ADDR_W-1:0] next_pc,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [DATA_W-1:0] push_data,
  output logic              push_last,
  output logic              vec_load,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              stall,
  output logic              irq_disabled,
  output logic              in_handler,
  output logic              frame_tick
);
  irqc_state_t state_q, state_d;
  irqc_src_t   src_q, sel_src;
  logic        dis_q, hnd_q;
  logic        dis_eff, hnd_eff, run;
  logic        any_pend, frame_pend, io_pend;
  logic        take_run, take_halt, take, push_done;

  irqc_frame_div #(.FRAME_DIV(FRAME_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick)
  );

  irqc_pending u_pend (
    .clk(clk), .rst_n(rst_n),
    .frame_set(frame_tick), .io_set(io_irq), .take(take),
    .sel_src(sel_src), .any_pend(any_pend),
    .frame_pend(frame_pend), .io_pend(io_pend)
  );

  irqc_pusher #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_push (
    .clk(clk), .rst_n(rst_n), .start(take), .ret_pc(next_pc),
    .push_valid(push_valid), .push_ready(push_ready),
    .push_data(push_data), .push_last(push_last), .done(push_done)
  );

  assign run = (state_q == ST_RUN);

  // strobes of this cycle applied before the boundary decision
  always_comb begin
    dis_eff = dis_q;
    hnd_eff = hnd_q;
    if (run) begin
      if (sif)                dis_eff = 1'b1;
      else if (iret)          dis_eff = 1'b0;
      else if (cif && !hnd_q) dis_eff = 1'b0;
      if (iret)               hnd_eff = 1'b0;
    end
  end

  assign take_run  = run && !halt && boundary && !dis_eff && any_pend;
  assign take_halt = (state_q == ST_HALT) && frame_pend;
  assign take      = take_run | take_halt;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (halt)      state_d = dis_eff ? ST_LOCK : ST_HALT;
        else if (take) state_d = ST_PUSH;
      end
      ST_HALT:   if (take) state_d = ST_PUSH;
      ST_PUSH:   if (push_done) state_d = ST_VECTOR;
      ST_VECTOR: state_d = ST_RUN;
      ST_LOCK:   state_d = ST_LOCK;
      default:   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      src_q   <= SRC_FRAME;
      dis_q   <= 1'b1;
      hnd_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take) begin
        dis_q <= 1'b1;
        hnd_q <= 1'b1;
        src_q <= take_halt ? SRC_FRAME : sel_src;
      end else begin
        dis_q <= dis_eff;
        hnd_q <= hnd_eff;
      end
    end
  end

  assign vec_load     = (state_q == ST_VECTOR);
  assign vec_addr     = ADDR_W'((src_q == SRC_FRAME) ? FRAME_VEC : IO_VEC);
  assign stall        = !run;
  assign irq_disabled = dis_q;
  assign in_handler   = hnd_q;

  p_take_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(push_valid) |-> (irq_disabled && in_handler && stall));
  p_take_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(push_valid) |-> ($past(boundary) || $past(state_q == ST_HALT)));
  p_cif_inside_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cif && !iret && in_handler) |=> irq_disabled);
  p_iret_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && iret && !sif && !take && !halt) |=> (!irq_disabled && !in_handler));
  p_vec_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_load |=> (!vec_load && !stall));
  p_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCK) |=> (stall && !push_valid && state_q == ST_LOCK));
endmodule

// File: tb/sim_irq_halt_ctrl.sv
`timescale 1ns/1ps
module sim_irq_halt_ctrl;
  localparam int DIV = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_irq = 0, boundary = 0, sif = 0, cif = 0, iret = 0, halt = 0;
  logic [15:0] next_pc = '0;
  logic push_ready = 0;
  logic push_valid, push_last, vec_load, stall, irq_disabled, in_handler, frame_tick;
  logic [7:0]  push_data;
  logic [15:0] vec_addr;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  irq_halt_ctrl #(.FRAME_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .io_irq(io_irq), .boundary(boundary),
    .sif(sif), .cif(cif), .iret(iret), .halt(halt), .next_pc(next_pc),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .push_last(push_last), .vec_load(vec_load), .vec_addr(vec_addr),
    .stall(stall), .irq_disabled(irq_disabled), .in_handler(in_handler),
    .frame_tick(frame_tick)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_sif();  sif = 1;  step(); sif = 0;  endtask
  task automatic pulse_cif();  cif = 1;  step(); cif = 0;  endtask
  task automatic pulse_iret(); iret = 1; step(); iret = 0; endtask
  task automatic pulse_halt(); halt = 1; step(); halt = 0; endtask
  task automatic pulse_io();   io_irq = 1; step(); io_irq = 0; endtask
  task automatic pulse_bnd(input logic [15:0] pc);
    next_pc = pc; boundary = 1; step(); boundary = 0;
  endtask

  task automatic wait_tick();
    for (int i = 0; i < 4 * DIV; i++) begin
      step();
      if (frame_tick) break;
    end
  endtask

  // push already started: drain both bytes and check the vector
  task automatic serve(input logic [15:0] pc, input logic [15:0] vec, input string tag);
    chk(push_valid && !push_last && push_data == pc[15:8], {tag, " R5 high byte"}, {push_valid, push_last, push_data}, {2'b10, pc[15:8]});
    push_ready = 1; step();
    chk(push_valid && push_last && push_data == pc[7:0], {tag, " R5 low byte"}, {push_valid, push_last, push_data}, {2'b11, pc[7:0]});
    step(); push_ready = 0;
    chk(vec_load && vec_addr == vec && stall, {tag, " R6 vector"}, {vec_load, vec_addr}, {1'b1, vec});
    step();
    chk(!vec_load && !stall && !push_valid, {tag, " R6 pulse end"}, {vec_load, stall}, 0);
  endtask

  task automatic t_reset();
    chk(irq_disabled && !in_handler && !stall && !push_valid && !vec_load, "R1 reset",
        {irq_disabled, in_handler, stall, push_valid, vec_load}, 5'b10000);
  endtask

  task automatic t_period();
    int n = 0;
    wait_tick();
    for (int i = 1; i <= 2 * DIV; i++) begin
      step();
      if (frame_tick) begin n = i; break; end
    end
    chk(n == DIV, "R2 tick period", n, DIV);
  endtask

  task automatic t_flag();
    pulse_cif();
    chk(!irq_disabled, "R3 cif clears", irq_disabled, 0);
    pulse_sif();
    chk(irq_disabled, "R3 sif sets", irq_disabled, 1);
  endtask

  task automatic t_frame();
    logic ok = 1;
    wait_tick();
    pulse_cif();
    chk(!stall, "R4 no take without boundary", stall, 0);
    pulse_bnd(16'h1234);
    chk(stall && irq_disabled && in_handler, "R4 take marks", {stall, irq_disabled, in_handler}, 3'b111);
    for (int i = 0; i < 3; i++) begin
      step();
      if (!(push_valid && push_data == 8'h12 && !push_last)) ok = 0;
    end
    chk(ok, "R5 hold under back-pressure", push_data, 8'h12);
    serve(16'h1234, 16'hFF00, "frame");
    pulse_cif();
    chk(irq_disabled, "R3 cif ignored in handler", irq_disabled, 1);
    pulse_iret();
    chk(!irq_disabled && !in_handler, "R8 iret clears", {irq_disabled, in_handler}, 0);
    pulse_sif();
  endtask

  task automatic t_io();
    pulse_io();
    pulse_bnd(16'h0BAD);
    chk(!stall && !push_valid, "R11 blocked while disabled", {stall, push_valid}, 0);
    wait_tick();
    pulse_cif();
    pulse_bnd(16'hABCD);
    serve(16'hABCD, 16'hFF00, "R7 frame first");
    pulse_iret();
    for (int i = 0; i < 3; i++) step();
    chk(!stall && !push_valid, "R4 pending waits for boundary", {stall, push_valid}, 0);
    pulse_bnd(16'h5A6B);
    chk(stall && push_valid, "R11 io taken later", {stall, push_valid}, 2'b11);
    serve(16'h5A6B, 16'hFF02, "R7 io second");
    pulse_iret();
    pulse_sif();
  endtask

  task automatic t_halt();
    int n = 0;
    wait_tick();
    pulse_cif();
    pulse_bnd(16'h2000);
    serve(16'h2000, 16'hFF00, "halt prep");
    pulse_iret();
    pulse_halt();
    chk(stall && !push_valid, "R9 halt stalls", {stall, push_valid}, 2'b10);
    for (int i = 1; i <= 2 * DIV; i++) begin
      if (push_valid) begin n = i; break; end
      step();
    end
    chk(n > 5 && n <= DIV, "R9 waits for frame", n, DIV);
    chk(in_handler && irq_disabled, "R9 handler entered", {in_handler, irq_disabled}, 2'b11);
    serve(16'h2000, 16'hFF00, "R9 halt wake");
    pulse_iret();
  endtask

  task automatic t_lock();
    logic ok = 1;
    pulse_sif();
    pulse_halt();
    push_ready = 1;
    for (int i = 0; i < 2 * DIV; i++) begin
      io_irq = 1; boundary = 1; cif = (i % 3 == 0); iret = (i % 5 == 0);
      step();
      if (!(stall && !push_valid && !vec_load)) ok = 0;
    end
    io_irq = 0; boundary = 0; cif = 0; iret = 0; push_ready = 0;
    chk(ok, "R10 permanent lock", {stall, push_valid}, 2'b10);
  endtask

  initial begin
    repeat (4) step();
    rst_n = 1;
    step();
    t_reset();
    t_period();
    t_flag();
    t_frame();
    t_io();
    t_halt();
    t_lock();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule